// File: doc/BRIEF.md
# Frequent Loop Profiler

This block sits beside a processor's fetch path and learns which loops the program spends its time in. It never asserts anything back toward the core. It only samples a taken-branch indication together with the branch address and its destination. A taken branch that jumps to a lower address counts as one pass through a loop. The destination address identifies the loop.

A small fully associative table holds one tag and one frequency counter per tracked loop. When a loop that is already tracked runs again, its counter goes up by one. When a new loop appears, it evicts the entry that has run least often. If a counter is about to reach full scale, every counter in the table is halved in the same cycle. The counts therefore remain a measure of how often each loop runs relative to the others, not an absolute total. Software or a test harness reads any entry by index, and the tag and count appear on the next clock.

Top module: `loop_profiler`

## Requirements
- R1: After synchronous reset every entry reads back with tag 0 and count 0, and the readout outputs are 0.
- R2: A valid branch whose destination is equal to or higher than the branch address changes no entry.
- R3: A valid backward branch whose destination matches no tracked tag allocates an entry with tag = destination and count = 1. Entries that have never been used have count 0, so they are filled from the lowest index upward.
- R4: A valid backward branch whose destination matches a tracked tag increments that entry's count by exactly 1 and leaves the other entries unchanged.
- R5: Matching uses only the destination address. Backward branches from different source addresses to the same destination update the same single entry.
- R6: With no free entry, a miss replaces the entry holding the smallest count, choosing the lowest index on a tie, and sets that entry's count to 1.
- R7: When an increment would make a count all ones (255 for an 8-bit counter), every count is shifted right by one in that same cycle. The hit entry stores (old+1)>>1, and no count ever holds all ones.
- R8: rd_idx is sampled on a clock edge, and rd_tag/rd_count show that entry's contents as of that edge from that edge onward.
- R9: While br_valid is low, no entry changes, whatever br_pc and br_target carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A taken branch is presented this cycle |
| br_pc | input | ADDR_W | Address of the branch |
| br_target | input | ADDR_W | Destination of the branch |
| rd_idx | input | IDX_W | Table entry selected for readout |
| rd_tag | output | ADDR_W | Loop tag of the selected entry, one cycle later |
| rd_count | output | CNT_W | Relative count of the selected entry, one cycle later |

## Verification
The profiler is driven with several kinds of branches:
- forward branches, self-branches and idle cycles with backward-looking addresses, which show that only real taken backward branches reach the table;
- repeated branches to one destination from different sources, which separate destination tagging from source tagging;
- a fill of every entry followed by misses, once with all counts tied and once with a single unique minimum, which separates the tie-break from the minimum search;
- a long run on one loop up to the brink of full scale and then one step past it, which shows that all entries are halved together rather than the hot entry simply clamping.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Table action chosen for one observed branch
    typedef enum logic [1:0] {
        LP_OP_IDLE,
        LP_OP_HIT,
        LP_OP_HALVE,
        LP_OP_ALLOC
    } lp_op_e;

    localparam int LP_MAX_ADDR_W = 64;

    // A loop closes when control flows back to a lower address
    function automatic logic lp_backward(input logic [LP_MAX_ADDR_W-1:0] src,
                                         input logic [LP_MAX_ADDR_W-1:0] dst);
        return dst < src;
    endfunction

endpackage

// File: rtl/lp_detect.sv
module lp_detect #(
    parameter int ADDR_W = 32
) (
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_target,
    output logic              loop_ev
);
    import lp_pkg::*;

    logic [LP_MAX_ADDR_W-1:0] pc_ext;
    logic [LP_MAX_ADDR_W-1:0] tgt_ext;

    assign pc_ext  = LP_MAX_ADDR_W'(br_pc);
    assign tgt_ext = LP_MAX_ADDR_W'(br_target);
    assign loop_ev = br_valid && lp_backward(pc_ext, tgt_ext);

endmodule

// File: rtl/lp_victim.sv
module lp_victim #(
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][CNT_W-1:0] cnt,
    output logic [IDX_W-1:0]              victim
);
    logic [CNT_W-1:0] best;

    // Strict less-than keeps the lowest index among equal minima
    always_comb begin
        best   = cnt[0];
        victim = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (cnt[i] < best) begin
                best   = cnt[i];
                victim = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lp_table.sv
module lp_table #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           loop_ev,
    input  logic [ADDR_W-1:0]              ev_tag,
    input  logic [IDX_W-1:0]               victim,
    output logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
    output logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q
);
    import lp_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_hit;
    logic [CNT_W-1:0]   hit_cnt;
    logic [CNT_W-1:0]   inc;
    logic               sat;
    lp_op_e             op;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit = |hit_vec;
    assign hit_cnt = cnt_q[hit_idx];
    assign inc     = hit_cnt + CNT_W'(1);
    assign sat     = (inc == CNT_MAX);

    always_comb begin
        op = LP_OP_IDLE;
        if (loop_ev) begin
            if (!any_hit)  op = LP_OP_ALLOC;
            else if (sat)  op = LP_OP_HALVE;
            else           op = LP_OP_HIT;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == ev_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                cnt_q[g]   <= '0;
            end else begin
                unique case (op)
                    LP_OP_HIT: begin
                        if (hit_vec[g]) cnt_q[g] <= inc;
                    end
                    LP_OP_HALVE: begin
                        cnt_q[g] <= hit_vec[g] ? (inc >> 1) : (cnt_q[g] >> 1);
                    end
                    LP_OP_ALLOC: begin
                        if (victim == IDX_W'(g)) begin
                            valid_q[g] <= 1'b1;
                            tag_q[g]   <= ev_tag;
                            cnt_q[g]   <= CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end

        AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] != CNT_MAX); // R7
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R5

    AST_HIT_PLUS_ONE: assert property (@(posedge clk) disable iff (rst)
        (op == LP_OP_HIT) |=> cnt_q[$past(hit_idx)] == $past(hit_cnt) + CNT_W'(1)); // R4

    AST_HALVE_HIT: assert property (@(posedge clk) disable iff (rst)
        (op == LP_OP_HALVE) |=> cnt_q[$past(hit_idx)] == ($past(hit_cnt) + CNT_W'(1)) >> 1); // R7

    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (rst)
        (op == LP_OP_ALLOC) |=> (cnt_q[$past(victim)] == CNT_W'(1))
                             && (tag_q[$past(victim)] == $past(ev_tag))); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == LP_OP_IDLE) |=> $stable(cnt_q) && $stable(tag_q)); // R2

endmodule

// File: rtl/loop_profiler.sv
module loop_profiler #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_tag,
    output logic [CNT_W-1:0]  rd_count
);
    logic                           loop_ev;
    logic [IDX_W-1:0]               victim;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;

    lp_detect #(.ADDR_W(ADDR_W)) u_detect (
        .br_valid  (br_valid),
        .br_pc     (br_pc),
        .br_target (br_target),
        .loop_ev   (loop_ev)
    );

    lp_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_victim (
        .cnt    (cnt_q),
        .victim (victim)
    );

    lp_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .loop_ev (loop_ev),
        .ev_tag  (br_target),
        .victim  (victim),
        .tag_q   (tag_q),
        .cnt_q   (cnt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tag   <= '0;
            rd_count <= '0;
        end else begin
            rd_tag   <= tag_q[rd_idx];
            rd_count <= cnt_q[rd_idx];
        end
    end

    AST_NO_LOOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !br_valid |-> !loop_ev); // R9

endmodule

// File: tb/loop_profiler_bench.sv
`timescale 1ns/1ps
module loop_profiler_bench;
    localparam int N   = 16;
    localparam int AW  = 32;
    localparam int CW  = 8;
    localparam int MAX = (1 << CW) - 1;

    typedef struct {
        logic [AW-1:0] tag;
        int            cnt;
        int            idx;
        int            cyc;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_pc = '0;
    logic [AW-1:0] br_target = '0;
    logic [3:0]    rd_idx = '0;
    logic [AW-1:0] rd_tag;
    logic [CW-1:0] rd_count;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    exp_t exp_q[$];

    logic [AW-1:0] mdl_tag[N];
    int            mdl_cnt[N];

    loop_profiler #(.ENTRIES(N), .ADDR_W(AW), .CNT_W(CW)) u_loop_profiler (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_pc(br_pc),
        .br_target(br_target), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_count(rd_count)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare results whose read was issued before the last edge
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_tag !== e.tag || int'(rd_count) != e.cnt) begin
                failures++;
                $display("FAIL %s idx=%0d: tag=%h cnt=%0d expected tag=%h cnt=%0d",
                         e.req, e.idx, rd_tag, rd_count, e.tag, e.cnt);
            end
        end
    end

    task automatic branch(input logic [AW-1:0] pc, input logic [AW-1:0] tgt);
        int h;
        int v;
        @(negedge clk);
        br_valid  = 1'b1;
        br_pc     = pc;
        br_target = tgt;
        if (tgt < pc) begin
            h = -1;
            for (int i = 0; i < N; i++)
                if (mdl_cnt[i] >= 0 && mdl_tag[i] == tgt && h < 0 && used[i]) h = i;
            if (h >= 0) begin
                if (mdl_cnt[h] + 1 == MAX) begin
                    for (int j = 0; j < N; j++) if (j != h) mdl_cnt[j] = mdl_cnt[j] >> 1;
                    mdl_cnt[h] = MAX >> 1;
                end else begin
                    mdl_cnt[h] = mdl_cnt[h] + 1;
                end
            end else begin
                v = 0;
                for (int i = 1; i < N; i++) if (mdl_cnt[i] < mdl_cnt[v]) v = i;
                used[v]    = 1'b1;
                mdl_tag[v] = tgt;
                mdl_cnt[v] = 1;
            end
        end
    endtask

    bit used[N];

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            exp_t e;
            @(negedge clk);
            br_valid = 1'b0;
            rd_idx   = 4'(i);
            e.tag = mdl_tag[i];
            e.cnt = mdl_cnt[i];
            e.idx = i;
            e.cyc = cyc;
            e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl_tag[i] = '0;
            mdl_cnt[i] = 0;
            used[i]    = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: readout outputs held at zero in reset
        checks++;
        if (rd_tag !== '0 || rd_count !== '0) begin
            failures++;
            $display("FAIL R1 reset readout: tag=%h cnt=%0d expected tag=0 cnt=0", rd_tag, rd_count);
        end
        rst = 1'b0;
        check_all("R1");

        // R2: forward and self branches leave table empty
        branch(32'h100, 32'h200);
        branch(32'h180, 32'h180);
        check_all("R2");

        // R9: backward-looking addresses with br_valid low
        @(negedge clk);
        br_valid = 1'b0; br_pc = 32'h500; br_target = 32'h10;
        repeat (4) @(negedge clk);
        check_all("R9");

        // R3: first misses fill lowest free entries
        branch(32'h200, 32'h100);
        branch(32'h300, 32'h280);
        check_all("R3");

        // R4/R5: hits from varying sources to one destination
        for (int k = 0; k < 5; k++) branch(32'h200 + 32'(k * 4), 32'h100);
        check_all("R5");
        check_all("R8");

        // Fill all entries, counts tied at 1 except entry 0
        for (int i = 2; i < N; i++) branch(32'h2000, 32'h1000 + 32'(i * 16));
        check_all("R3");

        // R6: tie among minima goes to lowest index (entry 1)
        branch(32'h5000, 32'h3000);
        check_all("R6");

        // R6: unique minimum at entry 9
        for (int i = 1; i < N; i++) if (i != 9) branch(32'h8000, mdl_tag[i]);
        branch(32'h5000, 32'h4000);
        check_all("R6");

        // R4: run entry 0 up to just below full scale
        while (mdl_cnt[0] != MAX - 1) branch(32'h900, 32'h100);
        check_all("R4");

        // R7: next hit halves every entry
        branch(32'h900, 32'h100);
        check_all("R7");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule